// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a 32-bit down-counter that a processor core programs through a small register port. A prescaler divides the clock by a power of two. Writing a start value loads the counter and restarts the prescaler at once. After that, the counter steps down once per prescaled tick.

There are two modes. In one-shot mode the count stops at zero. In periodic mode the count reloads itself and keeps running. Each time the count expires, the block emits a one-cycle strobe that carries an 8-bit vector taken from its control word. A mask bit in the control word blocks the strobe.

The current count can be read at any time, and reading it does not disturb the count.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset, the control word reads 0x00010000 (masked, one-shot, vector 0). The start value, the divide setting and the current count read 0, and `irq_valid` is 0.
- R2: A write to the divide setting keeps only bits 3, 1 and 0; the other bits are stored as 0. A readback of 0xF written returns 0xB, and 0x4 written behaves as 0x0.
- R3: The divide code is {bit3, bit1, bit0}. The shift is (code + 1) mod 8, and the count steps once every 2^shift clocks. So a setting of 0xB divides by 1, 0x0 by 2, 0x1 by 4, 0x8 by 32 and 0xA by 128.
- R4: A write to the start value loads the count at that clock edge and clears the prescaler. The first decrement lands 2^shift clocks after the write edge. A new write during a count restarts it.
- R5: In one-shot mode (bit 17 of the control word clear), the count stops at 0. Exactly one strobe is raised, in the cycle where the count becomes 0. A start value of 0 gives no strobe.
- R6: In periodic mode (bit 17 set), the tick that finds the count at 0 reloads the start value, so one period is start value + 1 ticks. Each reload raises one strobe.
- R7: In periodic mode with a start value of 0, no strobe is ever raised and the count stays 0.
- R8: With bit 16 of the control word set, an expiry raises no strobe. An expiry that passed while masked is not replayed on unmasking. Clearing the mask before expiry lets that expiry deliver.
- R9: The strobe carries bits 7:0 of the control word as `irq_vector`. The control word stores only bits 17, 16 and 7:0, and reads back 0 in all other bits.
- R10: `rd_data` is registered and shows the register picked by `rd_sel` one cycle later. The select codes are 0 control, 1 start value, 2 divide setting, 3 current count. Writes to code 3 are ignored, and reads never change the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register picked for write (0 control, 1 start value, 2 divide, 3 ignored) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register picked for read (0 control, 1 start value, 2 divide, 3 current count) |
| rd_data | output | 32 | Registered read data |
| irq_valid | output | 1 | One-cycle expiry strobe |
| irq_vector | output | 8 | Vector delivered with the strobe |

## Verification
The assertions assume that every register write takes effect at the next rising edge. They also assume that a start-value write is the only way the count can jump, so any step larger than one tick is treated as an error unless `wr_sel` selected the start value. Reset is assumed to be held for at least one clock before the checked properties are enabled.

The stimulus changes inputs only on falling clock edges. It holds reset for several cycles, and it never writes the control word in the same cycle as an expiry. Because of this, each strobe can be tied to the control state of the preceding cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int VEC_W          = 8;
  localparam int SHIFT_W        = 3;
  localparam int DIV_W          = 4;
  localparam int CTRL_MASK_BIT  = 16;
  localparam int CTRL_PER_BIT   = 17;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_INIT = 2'd1,
    SEL_DIV  = 2'd2,
    SEL_CUR  = 2'd3
  } tmr_sel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } tmr_ctrl_t;

  // Scattered divide field: code = {cfg[3], cfg[1:0]}, shift = code + 1 (wraps)
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_W-1:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + SHIFT_W'(1);
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output tmr_ctrl_t         ctrl_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [CNT_W-1:0]  init_q,
  output logic              init_load
);

  assign init_load = wr_en && (tmr_sel_e'(wr_sel) == SEL_INIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
      div_q  <= '0;
      init_q <= '0;
    end else if (wr_en) begin
      case (tmr_sel_e'(wr_sel))
        SEL_CTRL: begin
          ctrl_q.periodic <= wr_data[CTRL_PER_BIT];
          ctrl_q.masked   <= wr_data[CTRL_MASK_BIT];
          ctrl_q.vector   <= wr_data[VEC_W-1:0];
        end
        SEL_INIT: init_q <= wr_data[CNT_W-1:0];
        SEL_DIV:  div_q  <= {wr_data[3], 1'b0, wr_data[1:0]};
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);

  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_mask;

  // Tick when the low 'shift' bits are all ones: one tick per 2^shift clocks
  assign low_mask = (PRE_W'(1) << shift) - PRE_W'(1);
  assign tick     = (pre_q & low_mask) == low_mask;

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else                pre_q <= pre_q + PRE_W'(1);
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);

  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count_q;
    expire  = 1'b0;
    if (load) begin
      count_d = load_val;
    end else if (tick) begin
      if (count_q != '0) begin
        count_d = count_q - CNT_W'(1);
        expire  = !periodic && (count_q == CNT_W'(1));
      end else if (periodic && (reload_val != '0)) begin
        count_d = reload_val;
        expire  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);

  tmr_ctrl_t          ctrl_q;
  logic [DIV_W-1:0]   div_q;
  logic [CNT_W-1:0]   init_q;
  logic               init_load;
  logic               tick;
  logic [CNT_W-1:0]   cur_count;
  logic               expire;
  logic [DATA_W-1:0]  rd_mux;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .div_q    (div_q),
    .init_q   (init_q),
    .init_load(init_load)
  );

  tmr_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .restart(init_load),
    .shift  (div_shift(div_q)),
    .tick   (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (init_load),
    .load_val  (wr_data[CNT_W-1:0]),
    .reload_val(init_q),
    .tick      (tick),
    .periodic  (ctrl_q.periodic),
    .count_q   (cur_count),
    .expire    (expire)
  );

  always_comb begin
    rd_mux = '0;
    case (tmr_sel_e'(rd_sel))
      SEL_CTRL: begin
        rd_mux[CTRL_PER_BIT]  = ctrl_q.periodic;
        rd_mux[CTRL_MASK_BIT] = ctrl_q.masked;
        rd_mux[VEC_W-1:0]     = ctrl_q.vector;
      end
      SEL_INIT: rd_mux = DATA_W'(init_q);
      SEL_DIV:  rd_mux = DATA_W'(div_q);
      default:  rd_mux = DATA_W'(cur_count);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      rd_data   <= rd_mux;
      irq_valid <= expire && !ctrl_q.masked;
      if (expire) irq_vector <= ctrl_q.vector;
    end
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             irq_valid,
  input logic [7:0]       irq_vector,
  input logic             ctrl_masked,
  input logic             ctrl_periodic,
  input logic [7:0]       ctrl_vector,
  input logic [CNT_W-1:0] init_q,
  input logic [CNT_W-1:0] cur_count
);

  logic restart;
  assign restart = wr_en && (wr_sel == 2'd1);

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cur_count != '0 && !restart) |=>
      (cur_count == $past(cur_count) || cur_count == $past(cur_count) - CNT_W'(1)));

  p_saturate_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_periodic && cur_count == '0 && !restart) |=> cur_count == '0);

  p_expiry_value_r5: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (cur_count == '0 || cur_count == init_q));

  p_zero_period_r7: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !($past(ctrl_periodic) && $past(init_q) == '0));

  p_mask_r8: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !$past(ctrl_masked));

  p_vector_r9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_vector == $past(ctrl_vector));

endmodule

bind irq_countdown_timer tmr_checker #(.CNT_W(CNT_W)) u_tmr_checker (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .irq_valid    (irq_valid),
  .irq_vector   (irq_vector),
  .ctrl_masked  (ctrl_q.masked),
  .ctrl_periodic(ctrl_q.periodic),
  .ctrl_vector  (ctrl_q.vector),
  .init_q       (init_q),
  .cur_count    (cur_count)
);

// File: tb/test_irq_countdown_timer.sv
module test_irq_countdown_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  irq_countdown_timer i_irq_countdown_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  // {divide cfg, start value, periodic, clocks after write, expected read}
  localparam int NVEC = 10;
  localparam logic [84:0] VECS [NVEC] = '{
    {4'hB, 32'd100, 1'b0, 16'd11,  32'd90},
    {4'h0, 32'd100, 1'b0, 16'd21,  32'd90},
    {4'h1, 32'd50,  1'b0, 16'd41,  32'd40},
    {4'h8, 32'd10,  1'b0, 16'd65,  32'd8},
    {4'hA, 32'd5,   1'b0, 16'd257, 32'd3},
    {4'hB, 32'd5,   1'b0, 16'd21,  32'd0},
    {4'hB, 32'd4,   1'b1, 16'd8,   32'd2},
    {4'h0, 32'd3,   1'b1, 16'd12,  32'd2},
    {4'hF, 32'd20,  1'b0, 16'd6,   32'd15},
    {4'h4, 32'd20,  1'b0, 16'd11,  32'd15}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic watch(input int n, output int cnt, output int first, output logic [7:0] vec);
    cnt = 0; first = 0; vec = '0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (irq_valid) begin
        cnt++;
        if (first == 0) first = k;
        vec = irq_vector;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt, first;
    logic [7:0] vec;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq_valid", {31'd0, irq_valid}, 32'd0);
    rd(2'd0, v); check("R1 control", v, 32'h0001_0000);
    rd(2'd1, v); check("R1 start value", v, 32'd0);
    rd(2'd2, v); check("R1 divide", v, 32'd0);
    rd(2'd3, v); check("R1 count", v, 32'd0);

    // Table: R3 ratios, R4 restart, R5 saturation, R6 wrap, R2 dropped bits
    for (int i = 0; i < NVEC; i++) begin
      logic [84:0] e;
      e = VECS[i];
      rd_sel = 2'd3;
      wr(2'd2, {28'd0, e[84:81]});
      wr(2'd0, {14'd0, e[48], 1'b1, 16'd0});
      wr(2'd1, e[80:49]);
      repeat (int'(e[47:32])) @(negedge clk);
      check($sformatf("R3 R4 R5 R6 vector %0d", i), rd_data, e[31:0]);
    end

    // R2 divide readback
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R2 divide keeps 3,1,0", v, 32'hB);
    wr(2'd2, 32'h4);         rd(2'd2, v); check("R2 divide bit2 dropped", v, 32'h0);

    // R5 one-shot strobe
    wr(2'd2, 32'hB);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h0000_0041);
    wr(2'd1, 32'd3);
    watch(20, cnt, first, vec);
    check("R5 one-shot strobe count", cnt, 1);
    check("R5 one-shot strobe cycle", first, 3);
    check("R9 one-shot vector", {24'd0, vec}, 32'h41);
    rd(2'd3, v); check("R5 count held at 0", v, 32'd0);

    // R6 periodic strobes (control written while start value is 0: R7)
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h0002_005A);
    wr(2'd1, 32'd4);
    watch(22, cnt, first, vec);
    check("R6 periodic strobe count", cnt, 4);
    check("R6 periodic first strobe", first, 5);
    check("R9 periodic vector", {24'd0, vec}, 32'h5A);

    // R7 periodic with zero start value
    wr(2'd1, 32'd0);
    watch(30, cnt, first, vec);
    check("R7 no strobe", cnt, 0);
    rd(2'd3, v); check("R7 count stays 0", v, 32'd0);

    // R8 masked expiry not replayed
    wr(2'd0, 32'h0001_0000);
    wr(2'd1, 32'd3);
    watch(10, cnt, first, vec);
    check("R8 masked expiry silent", cnt, 0);
    wr(2'd0, 32'h0000_0033);
    watch(10, cnt, first, vec);
    check("R8 no replay on unmask", cnt, 0);

    // R8 unmask before expiry
    wr(2'd0, 32'h0001_0077);
    wr(2'd1, 32'd10);
    wr(2'd0, 32'h0000_0077);
    watch(20, cnt, first, vec);
    check("R8 unmasked in time count", cnt, 1);
    check("R8 unmasked in time cycle", first, 8);
    check("R9 late unmask vector", {24'd0, vec}, 32'h77);

    // R8 masked periodic
    wr(2'd0, 32'h0003_0000);
    wr(2'd1, 32'd2);
    watch(20, cnt, first, vec);
    check("R8 masked periodic silent", cnt, 0);

    // R9 control field storage
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R9 control readback", v, 32'h0003_00FF);
    wr(2'd0, 32'h0001_0000);

    // R10 readback, ignored write to count, non-disturbing reads
    wr(2'd2, 32'hA);
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, v); check("R10 start value readback", v, 32'h1234_5678);
    wr(2'd1, 32'd1000);
    wr(2'd3, 32'd5);
    rd(2'd3, v); check("R10 write to count ignored", v, 32'd1000);
    for (int k = 0; k < 3; k++) begin
      rd(2'd3, v); check("R10 read does not disturb", v, 32'd1000);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule